// File: doc/BRIEF.md
# TDM Slot Receiver

This block receives a time-division-multiplexed serial stream in which a frame holds up to four fixed-width slots. A frame sync marks the start of slot 0. Bits are shifted in most significant bit first. Each complete word is handed to a destination when its slot ends, but only if its slot is enabled in a receive mask. For each slot, a routing bit sends that slot's words either to a shared receive FIFO or to a private holding register. The private register raises its own request line for an external DMA engine.

The bit clock and frame sync are sampled by the system clock, so they must be much slower than it. Bits are captured on the falling edge of the bit clock, the edge opposite the one the transmitter launches on. In synchronous mode the receiver takes its clock and frame sync from the transmit pins instead of its own. The FIFO raises an interrupt while its fill count is above a programmable warning limit. Any word that has no room is discarded, and a sticky overrun flag records the loss.

Top module: `tdm_slot_rx`

## Requirements
- R1: No word is captured before the first frame sync after reset. A word whose slot has its `rx_assign` bit at 0 reaches neither the FIFO nor a holding register.
- R2: Data is sampled on the falling edge of the selected bit clock, most significant bit first. With `wlen16`=1 a word is 16 bits. With `wlen16`=0 it is 8 bits, zero-extended in bits 15:8.
- R3: An assigned slot with `dma_sel` bit 0 pushes its word into the FIFO. Words leave the FIFO in arrival order, and `fifo_rdata` shows the oldest word.
- R4: An assigned slot with `dma_sel` bit 1 stores its word only in that slot's holding register, raises `dma_req` for that slot, and leaves the FIFO unchanged.
- R5: A pulse on `dma_rd[n]` empties holding register n and drops `dma_req[n]` on the next clock.
- R6: `irq` is 1 exactly while `fifo_count` is greater than `warn_lim`. A count equal to the limit gives 0.
- R7: A word routed to a full FIFO is dropped and sets `overrun`. The flag stays set until reset, and the stored words are kept intact.
- R8: A word routed to a holding register that is still full, with no read in the same cycle, is dropped. The old word is kept and `overrun` is set.
- R9: With `sync_mode`=1 the receiver uses `tx_bclk` and `tx_fsync`. With `sync_mode`=0 it uses `rx_bclk` and `rx_fsync`, and activity on the other pair has no effect.
- R10: A rising frame sync sampled at a bit edge restarts at bit 0 of slot 0, discarding any partial word. After slot `slots_m1` the receiver ignores data until the next frame sync.
- R11: If a read of holding register n falls in the same cycle as a new word is written to it, the new word is stored, `dma_req[n]` stays 1, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1: use transmit clock and frame sync |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| sdata | input | 1 | Serial data in |
| wlen16 | input | 1 | Word length: 1 = 16 bits, 0 = 8 bits |
| slots_m1 | input | 2 | Slots per frame minus one |
| rx_assign | input | 4 | Per-slot capture enable |
| dma_sel | input | 4 | Per-slot routing: 1 = holding register, 0 = FIFO |
| warn_lim | input | 4 | FIFO warning limit |
| fifo_rd | input | 1 | Pop the FIFO head |
| fifo_rdata | output | 16 | FIFO head word |
| fifo_count | output | 4 | FIFO fill count |
| irq | output | 1 | FIFO level above limit |
| dma_rd | input | 4 | Per-slot holding register read strobe |
| dma_data | output | 64 | Holding registers, slot n at bits 16n+15:16n |
| dma_req | output | 4 | Per-slot holding register full |
| overrun | output | 1 | Sticky lost-word flag |

## Verification
A holding-register read and a new word written to the same register can fall in the same clock. The bench provokes this by raising `dma_rd` exactly in the cycle after the sampling edge of a slot's last bit, which is when that word is written. The outcome is judged at the ports: `dma_req` must stay high, `dma_data` must show the newer word, and `overrun` must stay clear. The same stimulus without the read is run separately to confirm that the drop path does flag an overrun.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  typedef enum logic {LEN_HALF = 1'b0, LEN_FULL = 1'b1} wlen_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing
  import tdm_rx_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int WORD_W = 16,
  localparam int CW    = idx_bits(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic              sdata,
  input  logic              wlen16,
  input  logic [CW-1:0]     slots_m1,
  output logic              wd_valid,
  output logic [CW-1:0]     wd_slot,
  output logic [WORD_W-1:0] wd_word
);
  localparam int SW = CW + 1;
  localparam int BW = idx_bits(WORD_W) + 1;
  localparam int HW = WORD_W / 2;
  localparam logic [SW-1:0] IDLE = SW'(NSLOT);

  logic              bclk_sel, fs_sel, bclk_q, fs_q;
  logic              se, fs_start, last_bit;
  logic [WORD_W-1:0] shreg, shift_n, word_n;
  logic [BW-1:0]     bit_cnt, bit_n, last_idx;
  logic [SW-1:0]     slot, slot_n;
  logic              done_n;

  assign bclk_sel = sync_mode ? tx_bclk  : rx_bclk;
  assign fs_sel   = sync_mode ? tx_fsync : rx_fsync;
  assign se       = bclk_q & ~bclk_sel;
  assign fs_start = se & fs_sel & ~fs_q;
  assign last_idx = (wlen_e'(wlen16) == LEN_FULL) ? BW'(WORD_W - 1) : BW'(HW - 1);
  assign last_bit = (bit_cnt == last_idx);
  assign shift_n  = {shreg[WORD_W-2:0], sdata};
  assign word_n   = (wlen_e'(wlen16) == LEN_FULL) ? shift_n
                  : {{(WORD_W-HW){1'b0}}, shift_n[HW-1:0]};

  always_comb begin
    bit_n  = bit_cnt;
    slot_n = slot;
    done_n = 1'b0;
    if (se) begin
      if (fs_start) begin
        slot_n = '0;
        bit_n  = BW'(1);
      end else if (slot != IDLE) begin
        if (last_bit) begin
          done_n = 1'b1;
          bit_n  = '0;
          slot_n = (slot == {1'b0, slots_m1}) ? IDLE : SW'(slot + 1'b1);
        end else begin
          bit_n = BW'(bit_cnt + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q   <= 1'b0;
      fs_q     <= 1'b0;
      shreg    <= '0;
      bit_cnt  <= '0;
      slot     <= IDLE;
      wd_valid <= 1'b0;
      wd_slot  <= '0;
      wd_word  <= '0;
    end else begin
      bclk_q   <= bclk_sel;
      wd_valid <= done_n;
      if (se) begin
        fs_q    <= fs_sel;
        shreg   <= shift_n;
        bit_cnt <= bit_n;
        slot    <= slot_n;
      end
      if (done_n) begin
        wd_slot <= slot[CW-1:0];
        wd_word <= word_n;
      end
    end
  end

  a_r2_half_word_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && !wlen16) |-> (wd_word[WORD_W-1:HW] == '0));

  a_r10_slot_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |-> (wd_slot <= slots_m1));

  a_r10_one_word_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wd_valid |=> !wd_valid);
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo
  import tdm_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 8,
  localparam int AW    = idx_bits(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              ovr_evt
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr, wptr_n, rptr_n;
  logic [CNT_W-1:0]  count_n;
  logic              full, do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & (count != '0);
  assign ovr_evt = push & full;
  assign rdata   = mem[rptr];

  always_comb begin
    wptr_n  = wptr;
    rptr_n  = rptr;
    count_n = count + CNT_W'(do_push) - CNT_W'(do_pop);
    if (do_push) wptr_n = (wptr == AW'(DEPTH - 1)) ? '0 : AW'(wptr + 1'b1);
    if (do_pop)  rptr_n = (rptr == AW'(DEPTH - 1)) ? '0 : AW'(rptr + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= count_n;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == CNT_W'(DEPTH)) && $stable(wptr));
endmodule

// File: rtl/tdm_rx_dreg.sv
module tdm_rx_dreg #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd,
  output logic [WORD_W-1:0] data,
  output logic              full,
  output logic              ovr_evt
);
  logic              full_n, load;

  assign load    = wr & (~full | rd);
  assign ovr_evt = wr & full & ~rd;

  always_comb begin
    full_n = full;
    if (rd)   full_n = 1'b0;
    if (load) full_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_n;
      if (load) data <= wdata;
    end
  end

  a_r4_req_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(wr));

  a_r5_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr) |=> !full);

  a_r8_keep_old_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && full && !rd) |=> $stable(data) && full);

  a_r11_read_write_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rd) |=> full && (data == $past(wdata)));
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
#(
  parameter int NSLOT      = 4,
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int CW        = idx_bits(NSLOT),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_mode,
  input  logic                    rx_bclk,
  input  logic                    rx_fsync,
  input  logic                    tx_bclk,
  input  logic                    tx_fsync,
  input  logic                    sdata,
  input  logic                    wlen16,
  input  logic [CW-1:0]           slots_m1,
  input  logic [NSLOT-1:0]        rx_assign,
  input  logic [NSLOT-1:0]        dma_sel,
  input  logic [CNT_W-1:0]        warn_lim,
  input  logic                    fifo_rd,
  output logic [WORD_W-1:0]       fifo_rdata,
  output logic [CNT_W-1:0]        fifo_count,
  output logic                    irq,
  input  logic [NSLOT-1:0]        dma_rd,
  output logic [NSLOT*WORD_W-1:0] dma_data,
  output logic [NSLOT-1:0]        dma_req,
  output logic                    overrun
);
  logic              rst_meta, rst_ni;
  logic              wd_valid;
  logic [CW-1:0]     wd_slot;
  logic [WORD_W-1:0] wd_word;
  logic              fifo_push, fifo_ovr, overrun_n;
  logic [NSLOT-1:0]  dreg_wr, dreg_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  tdm_rx_timing #(.NSLOT(NSLOT), .WORD_W(WORD_W)) u_timing (
    .clk(clk), .rst_n(rst_ni), .sync_mode(sync_mode),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
    .sdata(sdata), .wlen16(wlen16), .slots_m1(slots_m1),
    .wd_valid(wd_valid), .wd_slot(wd_slot), .wd_word(wd_word)
  );

  assign fifo_push = wd_valid & rx_assign[wd_slot] & ~dma_sel[wd_slot];

  tdm_rx_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_ni), .push(fifo_push), .push_data(wd_word),
    .pop(fifo_rd), .rdata(fifo_rdata), .count(fifo_count), .ovr_evt(fifo_ovr)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign dreg_wr[i] = wd_valid & (wd_slot == CW'(i)) & rx_assign[i] & dma_sel[i];
    tdm_rx_dreg #(.WORD_W(WORD_W)) u_dreg (
      .clk(clk), .rst_n(rst_ni), .wr(dreg_wr[i]), .wdata(wd_word), .rd(dma_rd[i]),
      .data(dma_data[i*WORD_W +: WORD_W]), .full(dma_req[i]), .ovr_evt(dreg_ovr[i])
    );
  end

  assign irq       = (fifo_count > warn_lim);
  assign overrun_n = overrun | fifo_ovr | (|dreg_ovr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overrun <= 1'b0;
    else if (rst_ni) overrun <= overrun_n;
  end

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(overrun) |-> overrun);

  a_r1_single_destination: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({fifo_push, dreg_wr}));

  a_r1_unassigned_dropped: assert property (@(posedge clk) disable iff (!rst_ni)
    (wd_valid && !rx_assign[wd_slot]) |=> $stable(fifo_count) || $past(fifo_rd));
endmodule

// File: tb/sim_tdm_slot_rx.sv
module sim_tdm_slot_rx;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, sync_mode;
  logic        rx_bclk, rx_fsync, tx_bclk, tx_fsync, sdata, wlen16;
  logic [1:0]  slots_m1;
  logic [3:0]  rx_assign, dma_sel, warn_lim, dma_rd, fifo_count, dma_req;
  logic        fifo_rd, irq, overrun;
  logic [15:0] fifo_rdata;
  logic [63:0] dma_data;

  int nchk = 0;
  int nerr = 0;
  int fr   = 1;
  bit done = 0;

  tdm_slot_rx u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .tx_bclk(tx_bclk), .tx_fsync(tx_fsync),
    .sdata(sdata), .wlen16(wlen16), .slots_m1(slots_m1), .rx_assign(rx_assign),
    .dma_sel(dma_sel), .warn_lim(warn_lim), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .fifo_count(fifo_count), .irq(irq), .dma_rd(dma_rd), .dma_data(dma_data),
    .dma_req(dma_req), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] wexp(input int f, input int s, input int len);
    logic [31:0] t;
    t = 32'(f * 40503 + s * 9127 + 77);
    return (len == 16) ? t[15:0] : {8'h00, t[7:0]};
  endfunction

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic drive_bit(input bit use_tx, input bit fs, input bit d, input logic [3:0] rdm);
    @(negedge clk);
    if (use_tx) begin tx_bclk = 1'b1; tx_fsync = fs; end
    else begin rx_bclk = 1'b1; rx_fsync = fs; end
    sdata = d;
    @(negedge clk);
    @(negedge clk);
    if (use_tx) tx_bclk = 1'b0; else rx_bclk = 1'b0;
    @(negedge clk);
    dma_rd = rdm;
    @(negedge clk);
    dma_rd = '0;
  endtask

  task automatic send_word(input bit use_tx, input bit fs0, input logic [15:0] w,
                           input int len, input logic [3:0] rdm_last);
    for (int b = len - 1; b >= 0; b--)
      drive_bit(use_tx, (b == len - 1) && fs0, w[b], (b == 0) ? rdm_last : 4'b0);
  endtask

  task automatic send_frame(input bit use_tx, input int f, input int len, input logic [3:0] rdm0);
    for (int s = 0; s < 4; s++)
      send_word(use_tx, s == 0, wexp(f, s, len), len, (s == 0) ? rdm0 : 4'b0);
    send_word(use_tx, 1'b0, 16'hA5C3, 16, 4'b0);
  endtask

  task automatic read_dma(input int i, input logic [15:0] e, input string r);
    chk(r, "dma_req set", 32'(dma_req[i]), 1);
    chk(r, "dma_data", 32'(dma_data[i*16 +: 16]), 32'(e));
    @(negedge clk); dma_rd[i] = 1'b1;
    @(negedge clk); dma_rd = '0;
    chk("R5", "dma_req cleared by read", 32'(dma_req[i]), 0);
  endtask

  task automatic pop_fifo(input logic [15:0] e, input string r);
    chk(r, "fifo head", 32'(fifo_rdata), 32'(e));
    @(negedge clk); fifo_rd = 1'b1;
    @(negedge clk); fifo_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sync_mode = 1'b0; rx_bclk = 1'b0; rx_fsync = 1'b0;
    tx_bclk = 1'b0; tx_fsync = 1'b0; sdata = 1'b0; wlen16 = 1'b1;
    slots_m1 = 2'd3; rx_assign = 4'hF; dma_sel = 4'h0; warn_lim = 4'd8;
    fifo_rd = 1'b0; dma_rd = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R7", "reset overrun", 32'(overrun), 0);
    chk("R3", "reset fifo_count", 32'(fifo_count), 0);
    chk("R4", "reset dma_req", 32'(dma_req), 0);
    chk("R6", "reset irq", 32'(irq), 0);

    // R1: data before any frame sync is not captured
    for (int k = 0; k < 3; k++) send_word(1'b0, 1'b0, 16'hFFFF, 16, 4'b0);
    chk("R1", "no capture before sync fifo", 32'(fifo_count), 0);
    chk("R1", "no capture before sync dma", 32'(dma_req), 0);

    // Sweep every assign mask with varied routing (R1, R2, R3, R4, R5)
    for (int m = 0; m < 16; m++) begin
      int nf;
      rx_assign = 4'(m);
      dma_sel   = 4'((m * 7 + 3) & 15);
      send_frame(1'b0, fr, 16, 4'b0);
      nf = 0;
      for (int s = 0; s < 4; s++) begin
        if (rx_assign[s] && dma_sel[s]) read_dma(s, wexp(fr, s, 16), "R4");
        else chk("R1", "no dma_req for slot", 32'(dma_req[s]), 0);
        if (rx_assign[s] && !dma_sel[s]) nf++;
      end
      chk("R3", "fifo_count after frame", 32'(fifo_count), 32'(nf));
      for (int s = 0; s < 4; s++)
        if (rx_assign[s] && !dma_sel[s]) pop_fifo(wexp(fr, s, 16), "R2");
      chk("R3", "fifo drained", 32'(fifo_count), 0);
      fr++;
    end
    chk("R7", "no overrun in sweep", 32'(overrun), 0);

    // R10 slots-per-frame and R2 8-bit words
    wlen16 = 1'b0; rx_assign = 4'hF; dma_sel = 4'h0;
    for (int k = 0; k < 4; k++) begin
      slots_m1 = 2'(k);
      send_frame(1'b0, fr, 8, 4'b0);
      chk("R10", "words per frame", 32'(fifo_count), 32'(k + 1));
      for (int s = 0; s <= k; s++) pop_fifo(wexp(fr, s, 8), "R2");
      fr++;
    end

    // R9 clock source selection
    do_reset();
    send_frame(1'b1, fr, 16, 4'b0);
    chk("R9", "tx pins ignored when async", 32'(fifo_count), 0);
    sync_mode = 1'b1;
    send_frame(1'b1, fr, 16, 4'b0);
    chk("R9", "sync mode count", 32'(fifo_count), 4);
    for (int s = 0; s < 4; s++) pop_fifo(wexp(fr, s, 16), "R9");
    fr++;

    // R6 irq threshold and R7 FIFO overrun
    do_reset();
    warn_lim = 4'd4;
    send_frame(1'b0, fr, 16, 4'b0);
    chk("R6", "count equal to limit", 32'(fifo_count), 4);
    chk("R6", "irq low at limit", 32'(irq), 0);
    send_frame(1'b0, fr + 1, 16, 4'b0);
    chk("R6", "count above limit", 32'(fifo_count), 8);
    chk("R6", "irq high above limit", 32'(irq), 1);
    chk("R7", "no overrun yet", 32'(overrun), 0);
    send_frame(1'b0, fr + 2, 16, 4'b0);
    chk("R7", "count held when full", 32'(fifo_count), 8);
    chk("R7", "overrun set", 32'(overrun), 1);
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 4; s++) pop_fifo(wexp(fr + f, s, 16), "R7");
    chk("R6", "irq low when empty", 32'(irq), 0);
    chk("R7", "overrun sticky", 32'(overrun), 1);
    fr += 3;

    // R8 holding register overrun
    do_reset();
    rx_assign = 4'h1; dma_sel = 4'h1;
    send_frame(1'b0, fr, 16, 4'b0);
    chk("R4", "req after first word", 32'(dma_req), 1);
    chk("R4", "fifo untouched", 32'(fifo_count), 0);
    send_frame(1'b0, fr + 1, 16, 4'b0);
    chk("R8", "overrun on full register", 32'(overrun), 1);
    read_dma(0, wexp(fr, 0, 16), "R8");
    fr += 2;

    // R11 read coinciding with write
    do_reset();
    rx_assign = 4'h1; dma_sel = 4'h1;
    send_frame(1'b0, fr, 16, 4'b0);
    send_frame(1'b0, fr + 1, 16, 4'b0001);
    chk("R11", "no overrun on same-cycle read", 32'(overrun), 0);
    read_dma(0, wexp(fr + 1, 0, 16), "R11");
    fr += 2;

    // R10 frame sync restart mid-word
    do_reset();
    rx_assign = 4'h1; dma_sel = 4'h0; slots_m1 = 2'd0;
    drive_bit(1'b0, 1'b1, 1'b1, 4'b0);
    for (int k = 0; k < 4; k++) drive_bit(1'b0, 1'b0, 1'b1, 4'b0);
    send_word(1'b0, 1'b1, 16'h1234, 16, 4'b0);
    send_word(1'b0, 1'b0, 16'hFFFF, 16, 4'b0);
    chk("R10", "restart count", 32'(fifo_count), 1);
    pop_fifo(16'h1234, "R10");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule